// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block holds the register state of a byte-addressed GPIO expander whose pins are grouped into banks of eight. A serial-bus front end, not part of this block, loads an 8-bit register pointer and then streams write bytes or read strobes. Every register kind is replicated once per bank. The copies of one kind sit next to each other, and each kind's first address is its group number shifted left by a bank shift that is derived from the pin count. The block drives pin output levels and output enables. It samples the pins through a two-flop synchronizer and exports pull enable and pull direction bits for the pad ring. It also raises a level interrupt when a pin configured as an input changes state.

The pointer byte carries two flags. The top bit turns on pointer stepping across a burst. The next bit selects the pin-control set, a second register space that holds input-latch enables, pull controls, interrupt masks and interrupt flags. Accesses to read-only kinds, to group numbers with no register, or to bank slots at or above the bank count are dropped without effect. Reads of any of those addresses return zero.

Top module: `gpx_regfile`

## Requirements
- R1: A 7-bit pointer value (flags bit 6 plus offset bits 5:0) maps to register kind `offset >> S` and bank `offset & (2^S-1)`. S is the bit length of `(PIN_COUNT-1)/8`, so S=2 for the default of 20 pins. With bit 6 clear the kinds are: 0 input, 1 output level, 2 polarity invert, 3 direction.
- R2: After reset, direction and output level hold all ones and every other register holds zero. So pin_oe_o is all zeros, pin_o is all ones, and pull_en_o, pull_sel_o and irq_o are zero.
- R3: A direction bit of 1 makes the pin an input (pin_oe_o low). A bit of 0 enables the output, which drives the pin's output-level bit on pin_o. Both take effect on the clock edge that performs the write.
- R4: Reading the input kind returns each pin, after two synchronizer flops, XORed with its polarity invert bit.
- R5: When pointer bit 7 is set, every read or write strobe advances the 7-bit pointer by one, so a burst walks consecutive registers.
- R6: When pointer bit 7 is clear, every strobe of a burst accesses the same register.
- R7: Writes to the input kind and to the interrupt flag kind have no effect.
- R8: Writes to an undefined kind, or to a bank slot not below the bank count, have no effect. Reads of such addresses return 0x00.
- R9: With bit 6 set the kinds are: 2 input-latch enable, 3 pull enable, 4 pull direction (1 = up, 0 = down), 5 interrupt mask, 6 interrupt flags (read-only). Pull enable and pull direction drive pull_en_o and pull_sel_o.
- R10: Bits of the last bank above PIN_COUNT read as zero in every kind.
- R11: A level change on a pin whose direction bit is 1 and whose mask bit is 0 sets that pin's flag. Reading the flags does not clear them. irq_o is the OR of all flags. Reading a bank's input register clears that bank's flags, and a new change in the same cycle wins over the clear.
- R12: For a pin whose input-latch bit is 1, the input read returns the level captured at the first change since the last input read of that bank, XORed with polarity, instead of the live level.
- R13: rdata_o and rvalid_o are registered and appear on the clock edge that samples rd_en_i. rvalid_o is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load pointer and flags from addr_i |
| addr_i | input | 8 | Bit 7 step flag, bit 6 control-set flag, bits 5:0 offset |
| wr_en_i | input | 1 | Write strobe for wdata_i |
| wdata_i | input | 8 | Write byte |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | rdata_o holds the result of a read |
| pin_i | input | PIN_COUNT | Raw pin levels |
| pin_o | output | PIN_COUNT | Output levels |
| pin_oe_o | output | PIN_COUNT | Output enables |
| pull_en_o | output | PIN_COUNT | Pull resistor enable |
| pull_sel_o | output | PIN_COUNT | Pull direction, 1 = up |
| irq_o | output | 1 | Any interrupt flag set |

## Verification
Three pin patterns (0x3C, 0x5A and 0x09 across the three banks), combined with zero and all-ones polarity masks, separate synchronized levels from inverted ones and expose any mix-up of bank order. Bursts with the step flag set and then clear, run over the same bank triple, separate stepping from holding. A partial third bank shows whether out-of-range bits are masked. Interrupt tests toggle an output pin, a masked input and an unmasked input. This separates the direction gate from the mask gate. A pulse on a latched pin that returns to its old level before the read tells captured values apart from live ones.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef enum logic [3:0] {
    K_IN, K_OUT, K_POL, K_CFG, K_LAT, K_PEN, K_PSEL, K_MSK, K_STAT, K_NONE
  } reg_kind_e;

  // bit length of (pins-1)/8
  function automatic int bank_shift(input int pins);
    int q;
    int n;
    q = (pins - 1) / 8;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if ((q >> i) != 0) n = i + 1;
    end
    return n;
  endfunction

  function automatic logic [7:0] bank_mask(input int idx, input int pins);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (idx * 8 + i) < pins;
    return m;
  endfunction

endpackage

// File: rtl/gpx_addr_decode.sv
module gpx_addr_decode
  import gpx_pkg::*;
#(
  parameter int NBANK = 3,
  parameter int SHIFT = 2
) (
  input  logic [6:0] addr_i,
  output reg_kind_e  kind_o,
  output logic [2:0] bank_o,
  output logic       rd_ok_o,
  output logic       wr_ok_o
);

  logic [5:0] off;
  logic [5:0] grp;
  logic [5:0] bnk;

  assign off = addr_i[5:0];
  assign grp = off >> SHIFT;
  assign bnk = off & 6'((1 << SHIFT) - 1);

  always_comb begin
    kind_o = K_NONE;
    if (!addr_i[6]) begin
      case (grp)
        6'd0: kind_o = K_IN;
        6'd1: kind_o = K_OUT;
        6'd2: kind_o = K_POL;
        6'd3: kind_o = K_CFG;
        default: kind_o = K_NONE;
      endcase
    end else begin
      case (grp)
        6'd2: kind_o = K_LAT;
        6'd3: kind_o = K_PEN;
        6'd4: kind_o = K_PSEL;
        6'd5: kind_o = K_MSK;
        6'd6: kind_o = K_STAT;
        default: kind_o = K_NONE;
      endcase
    end
    if (int'(bnk) >= NBANK) kind_o = K_NONE;
  end

  assign bank_o  = bnk[2:0];
  assign rd_ok_o = (kind_o != K_NONE);
  assign wr_ok_o = rd_ok_o && (kind_o != K_IN) && (kind_o != K_STAT);

endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
#(
  parameter int PINS = 20,
  parameter int IDX  = 0,
  parameter int BW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] pin_i,
  input  logic          we_i,
  input  reg_kind_e     wkind_i,
  input  logic [7:0]    wdata_i,
  input  reg_kind_e     rkind_i,
  input  logic          in_rd_i,
  output logic [7:0]    rdata_o,
  output logic [BW-1:0] out_o,
  output logic [BW-1:0] oe_o,
  output logic [BW-1:0] pen_o,
  output logic [BW-1:0] psel_o,
  output logic          irq_o
);

  localparam logic [7:0] VMASK = bank_mask(IDX, PINS);

  logic [7:0] pin_pad;
  logic [7:0] out_q, pol_q, cfg_q, lat_q, pen_q, psel_q, msk_q;
  logic [7:0] stat_q, sync1_q, sync2_q, prev_q, hold_q, hvld_q;
  logic [7:0] change, stat_base, hvld_base, use_hold, in_val;

  always_comb begin
    pin_pad = '0;
    pin_pad[BW-1:0] = pin_i;
  end

  // input pins only
  assign change    = (sync2_q ^ prev_q) & cfg_q & VMASK;
  assign stat_base = in_rd_i ? 8'h00 : stat_q;
  assign hvld_base = in_rd_i ? 8'h00 : hvld_q;
  assign use_hold  = hvld_q & lat_q;
  assign in_val    = (((use_hold & hold_q) | (~use_hold & sync2_q)) ^ pol_q) & VMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= VMASK;
      cfg_q   <= VMASK;
      pol_q   <= '0;
      lat_q   <= '0;
      pen_q   <= '0;
      psel_q  <= '0;
      msk_q   <= '0;
      stat_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      hold_q  <= '0;
      hvld_q  <= '0;
    end else begin
      sync1_q <= pin_pad & VMASK;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      stat_q  <= stat_base | (change & ~msk_q);
      hvld_q  <= hvld_base | (change & lat_q);
      for (int i = 0; i < 8; i++) begin
        if (change[i] && lat_q[i] && !hvld_base[i]) hold_q[i] <= sync2_q[i];
      end
      if (we_i) begin
        case (wkind_i)
          K_OUT:  out_q  <= wdata_i & VMASK;
          K_POL:  pol_q  <= wdata_i & VMASK;
          K_CFG:  cfg_q  <= wdata_i & VMASK;
          K_LAT:  lat_q  <= wdata_i & VMASK;
          K_PEN:  pen_q  <= wdata_i & VMASK;
          K_PSEL: psel_q <= wdata_i & VMASK;
          K_MSK:  msk_q  <= wdata_i & VMASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rkind_i)
      K_IN:    rdata_o = in_val;
      K_OUT:   rdata_o = out_q;
      K_POL:   rdata_o = pol_q;
      K_CFG:   rdata_o = cfg_q;
      K_LAT:   rdata_o = lat_q;
      K_PEN:   rdata_o = pen_q;
      K_PSEL:  rdata_o = psel_q;
      K_MSK:   rdata_o = msk_q;
      K_STAT:  rdata_o = stat_q;
      default: rdata_o = 8'h00;
    endcase
  end

  assign out_o  = out_q[BW-1:0];
  assign oe_o   = ~cfg_q[BW-1:0];
  assign pen_o  = pen_q[BW-1:0];
  assign psel_o = psel_q[BW-1:0];
  assign irq_o  = |stat_q;

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int PIN_COUNT = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 addr_load_i,
  input  logic [7:0]           addr_i,
  input  logic                 wr_en_i,
  input  logic [7:0]           wdata_i,
  input  logic                 rd_en_i,
  output logic [7:0]           rdata_o,
  output logic                 rvalid_o,
  input  logic [PIN_COUNT-1:0] pin_i,
  output logic [PIN_COUNT-1:0] pin_o,
  output logic [PIN_COUNT-1:0] pin_oe_o,
  output logic [PIN_COUNT-1:0] pull_en_o,
  output logic [PIN_COUNT-1:0] pull_sel_o,
  output logic                 irq_o
);

  localparam int NBANK = (PIN_COUNT + 7) / 8;
  localparam int SHIFT = bank_shift(PIN_COUNT);

  logic [6:0]  ptr_q;
  logic        ai_q;
  logic [7:0]  rdata_q;
  logic        rvalid_q;
  reg_kind_e   dec_kind;
  logic [2:0]  dec_bank;
  logic        dec_rd_ok, dec_wr_ok;
  logic        acc_wr, acc_rd;
  logic [7:0]  bank_rd [NBANK];
  logic [NBANK-1:0] bank_irq;
  logic [7:0]  rd_sel;

  assign acc_wr = wr_en_i && !addr_load_i;
  assign acc_rd = rd_en_i && !addr_load_i;

  gpx_addr_decode #(.NBANK(NBANK), .SHIFT(SHIFT)) i_dec (
    .addr_i (ptr_q),
    .kind_o (dec_kind),
    .bank_o (dec_bank),
    .rd_ok_o(dec_rd_ok),
    .wr_ok_o(dec_wr_ok)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int BW = (PIN_COUNT - b * 8 >= 8) ? 8 : PIN_COUNT - b * 8;
    logic sel;
    assign sel = dec_rd_ok && (int'(dec_bank) == b);

    gpx_bank #(.PINS(PIN_COUNT), .IDX(b), .BW(BW)) i_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[b*8 +: BW]),
      .we_i   (acc_wr && dec_wr_ok && sel),
      .wkind_i(dec_kind),
      .wdata_i(wdata_i),
      .rkind_i(dec_kind),
      .in_rd_i(acc_rd && sel && (dec_kind == K_IN)),
      .rdata_o(bank_rd[b]),
      .out_o  (pin_o[b*8 +: BW]),
      .oe_o   (pin_oe_o[b*8 +: BW]),
      .pen_o  (pull_en_o[b*8 +: BW]),
      .psel_o (pull_sel_o[b*8 +: BW]),
      .irq_o  (bank_irq[b])
    );
  end

  always_comb begin
    rd_sel = 8'h00;
    for (int b = 0; b < NBANK; b++) begin
      if (dec_rd_ok && int'(dec_bank) == b) rd_sel = bank_rd[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      ai_q     <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= acc_rd;
      if (acc_rd) rdata_q <= rd_sel;
      if (addr_load_i) begin
        ptr_q <= addr_i[6:0];
        ai_q  <= addr_i[7];
      end else if ((wr_en_i || rd_en_i) && ai_q) begin
        ptr_q <= ptr_q + 7'd1;
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = |bank_irq;

endmodule

// File: rtl/gpx_regfile_chk.sv
module gpx_regfile_chk #(
  parameter int PIN_COUNT = 20
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 addr_load_i,
  input logic                 wr_en_i,
  input logic                 rd_en_i,
  input logic [7:0]           rdata_o,
  input logic                 rvalid_o,
  input logic [PIN_COUNT-1:0] pin_o,
  input logic [PIN_COUNT-1:0] pin_oe_o,
  input logic [PIN_COUNT-1:0] pull_en_o,
  input logic [PIN_COUNT-1:0] pull_sel_o,
  input logic [6:0]           ptr_i,
  input logic                 ai_i,
  input logic                 rd_ok_i
);

  // R13
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !addr_load_i) |=> rvalid_o);

  // R13
  no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !addr_load_i) |=> !rvalid_o);

  // R6
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || rd_en_i) && !addr_load_i && !ai_i) |=> $stable(ptr_i));

  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || rd_en_i) && !addr_load_i && ai_i) |=> (ptr_i == 7'($past(ptr_i) + 7'd1)));

  // R8
  bad_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !addr_load_i && !rd_ok_i) |=> (rdata_o == 8'h00));

  // R3
  pins_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pin_o) && $stable(pin_oe_o)));

  // R9
  pull_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pull_en_o) && $stable(pull_sel_o)));

endmodule

bind gpx_regfile gpx_regfile_chk #(.PIN_COUNT(PIN_COUNT)) i_gpx_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_load_i(addr_load_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .pull_en_o  (pull_en_o),
  .pull_sel_o (pull_sel_o),
  .ptr_i      (ptr_q),
  .ai_i       (ai_q),
  .rd_ok_i    (dec_rd_ok)
);

// File: tb/test_gpx_regfile.sv
module test_gpx_regfile;

  localparam int P = 20;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         addr_load_i = 1'b0;
  logic [7:0]   addr_i = '0;
  logic         wr_en_i = 1'b0;
  logic [7:0]   wdata_i = '0;
  logic         rd_en_i = 1'b0;
  logic [7:0]   rdata_o;
  logic         rvalid_o;
  logic [P-1:0] pin_i = '0;
  logic [P-1:0] pin_o, pin_oe_o, pull_en_o, pull_sel_o;
  logic         irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk_i = ~clk_i;

  gpx_regfile #(.PIN_COUNT(P)) i_gpx_regfile (.*);

  // monitor
  always @(negedge clk_i) begin
    if (rvalid_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R13 unexpected read actual=%h expected=none", rdata_o);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata_o !== e) begin
          n_err++;
          $display("FAIL %s actual=%h expected=%h", t, rdata_o, e);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic load(input logic [7:0] a);
    addr_load_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    addr_load_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    load(a); wr(d);
  endtask

  task automatic rreg(input logic [7:0] a, input logic [7:0] e, input string t);
    load(a); rd(e, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  // default map: shift 2, 3 banks; kind k at k*4+bank, control set +0x40
  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R2 reset state
    chk(pin_oe_o, 20'h00000, "R2 oe after reset");
    chk(pin_o, 20'hFFFFF, "R2 out after reset");
    chk(pull_en_o, 20'h0, "R2 pull_en after reset");
    chk(irq_o, 1'b0, "R2 irq after reset");
    rreg(8'h0C, 8'hFF, "R2 R1 cfg b0");
    rreg(8'h0E, 8'h0F, "R2 R10 cfg b2 partial");
    rreg(8'h05, 8'hFF, "R2 R1 out b1");
    rreg(8'h08, 8'h00, "R2 pol b0");
    rreg(8'h00, 8'h00, "R4 in b0 idle");

    // R9 R5 mask burst
    load(8'hD4); wr(8'hFF); wr(8'hFF); wr(8'hFF);
    load(8'hD4);
    rd(8'hFF, "R9 R5 msk b0"); rd(8'hFF, "R9 R5 msk b1"); rd(8'h0F, "R10 msk b2");

    // R4 sync and polarity
    pin_i = 20'h95A3C;
    wreg(8'h09, 8'hFF);
    idle(4);
    rreg(8'h00, 8'h3C, "R4 in b0");
    rreg(8'h01, 8'hA5, "R4 in b1 inverted");
    rreg(8'h02, 8'h09, "R4 R10 in b2");

    // R3 direction and level
    wreg(8'h04, 8'h55);
    wreg(8'h0C, 8'hF0);
    chk(pin_oe_o, 20'h0000F, "R3 oe");
    chk(pin_o[7:0], 8'h55, "R3 level");

    // R5 stepping burst
    load(8'h84); wr(8'h11); wr(8'h22); wr(8'h33);
    chk(pin_o, 20'h32211, "R5 R10 out burst");
    load(8'h84);
    rd(8'h11, "R5 out b0"); rd(8'h22, "R5 out b1"); rd(8'h03, "R5 R10 out b2");

    // R6 fixed pointer
    load(8'h08); wr(8'h12); wr(8'h34);
    load(8'h08);
    rd(8'h34, "R6 pol b0 first"); rd(8'h34, "R6 pol b0 repeat");
    rreg(8'h09, 8'hFF, "R6 pol b1 untouched");

    // R7 read-only kinds
    wreg(8'h00, 8'hFF);
    rreg(8'h04, 8'h11, "R7 out b0 after in write");
    rreg(8'h00, 8'h08, "R7 in b0 after write");
    wreg(8'h58, 8'hFF);
    rreg(8'h58, 8'h00, "R7 stat b0 after write");
    chk(irq_o, 1'b0, "R7 irq after stat write");

    // R8 invalid addresses
    wreg(8'h07, 8'h77);
    rreg(8'h07, 8'h00, "R8 bank3 slot");
    load(8'h84);
    rd(8'h11, "R8 out b0 kept"); rd(8'h22, "R8 out b1 kept"); rd(8'h03, "R8 out b2 kept");
    wreg(8'h10, 8'h99);
    rreg(8'h10, 8'h00, "R8 std kind 4");
    rreg(8'h44, 8'h00, "R8 ctl kind 1");
    rreg(8'h4B, 8'h00, "R8 ctl bank3");

    // R9 pulls
    wreg(8'h4C, 8'hF0);
    wreg(8'h52, 8'h0A);
    chk(pull_en_o, 20'h000F0, "R9 pull_en");
    chk(pull_sel_o, 20'hA0000, "R9 pull_sel");
    rreg(8'h4C, 8'hF0, "R9 pen b0");

    // R11 interrupts
    wreg(8'h54, 8'h00);
    pin_i[1] = ~pin_i[1];
    idle(5);
    chk(irq_o, 1'b0, "R11 output pin change");
    pin_i[4] = ~pin_i[4];
    idle(5);
    chk(irq_o, 1'b1, "R11 input pin change");
    rreg(8'h58, 8'h10, "R11 stat b0");
    chk(irq_o, 1'b1, "R11 stat read keeps flag");
    rreg(8'h00, 8'h1A, "R11 R4 in b0 live");
    chk(irq_o, 1'b0, "R11 clear on input read");
    rreg(8'h58, 8'h00, "R11 stat b0 cleared");
    pin_i[13] = ~pin_i[13];
    idle(5);
    chk(irq_o, 1'b0, "R11 masked change");
    rreg(8'h59, 8'h00, "R11 stat b1 masked");

    // R12 latch
    wreg(8'h48, 8'h80);
    pin_i[7] = 1'b1;
    idle(5);
    pin_i[7] = 1'b0;
    idle(5);
    chk(irq_o, 1'b1, "R12 flag from pulse");
    rreg(8'h00, 8'h9A, "R12 in b0 held");
    rreg(8'h00, 8'h1A, "R12 in b0 live after read");
    rreg(8'h58, 8'h00, "R12 stat cleared");

    idle(3);
    chk(exp_q.size(), 0, "R13 all reads returned");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule